// File: doc/BRIEF.md
# Byte-Addressed Pin Control Register File

This block is a byte-wide register file that controls a bank of general-purpose pins. A bus master reads and writes single bytes in a small address window. The bottom eight offsets form a read-only bank of level bytes. The next 36 offsets each hold the control byte of one pin. In that byte, bit 2 enables the output, bit 0 holds the output value, and bit 1 reports the pin state that was last observed. Outside logic reports the state of a pin through an event strobe that carries a pin index and a state bit. When the pin is an output, a bus write also updates the state bit, which then takes a copy of the written output value.

Two pins are wired to interrupt outputs. Pin 1 drives an active-low level interrupt. Pin 9 drives an edge interrupt that follows its state. A non-maskable interrupt request produces a one-cycle pulse on pin 9. The interrupt outputs change only when an event (an external one or the pulse sequencer) actually changes a pin's state. A bus write never moves them. Two one-cycle flags report an input event on a pin configured as output, and an input event on a pin that has no interrupt routing.

Top module: `gpio_ctl_regfile`

## Requirements
- R1: After reset, every control byte reads 0x00 except pin 1, which reads 0x02. Both interrupt outputs, both flags and the read data are 0.
- R2: A read strobe with an address loads bus_rdata at the next clock edge. The value is held until the next read strobe.
- R3: Offsets 0 to 7 read 0x00. Writes to them change no control byte.
- R4: Offsets 44 to 63 read 0x00. Writes to them change no control byte.
- R5: A write to offset 8+n sets bits 7:3, bit 2 and bit 0 of pin n's byte to the written bits. Bit 1 takes written bit 0 when written bit 2 is 1 and otherwise keeps its value. Written bit 1 is discarded.
- R6: An input event for pin n below 36 replaces only bit 1 of that pin's byte with the event state. An event with an index of 36 or above changes no byte.
- R7: When an event changes pin 1's state, irq_level_n_pin becomes the inverse of the new state at the same clock edge. An event that leaves the byte unchanged, or any bus write, leaves this output as it is.
- R8: When an event changes pin 9's state, irq_edge_pin becomes the new state at the same clock edge. An event that does not change the state leaves it as it is.
- R9: When nmi_req is sampled while the sequencer is idle, pin 9's state is set to 1 at the next edge and cleared at the edge after that. irq_edge_pin is therefore high for exactly one cycle. Requests that arrive during this sequence are ignored.
- R10: An in-range event on a pin whose stored bit 2 is 1 raises err_in_on_output for one cycle after the edge. Bit 1 is still updated.
- R11: An event whose index is neither 1 nor 9 raises err_unrouted for one cycle after the edge. Events on pins 1 and 9 leave it low.
- R12: Updates within one cycle are applied in a fixed order: first the bus write, then the external event, then the sequencer step. Whichever is applied last sets bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pin_evt_valid | input | 1 | External pin state event strobe |
| pin_evt_idx | input | 6 | Pin index of the event |
| pin_evt_state | input | 1 | Observed pin state |
| nmi_req | input | 1 | Non-maskable interrupt request |
| irq_level_n_pin | output | 1 | Level interrupt from pin 1 (high while pin 1 state is 0) |
| irq_edge_pin | output | 1 | Edge interrupt from pin 9 |
| err_in_on_output | output | 1 | One-cycle flag for an input event on an output pin |
| err_unrouted | output | 1 | One-cycle flag for an event on an unrouted pin |

## Verification
Two things can land on the same control byte in one clock: a bus write and an external event can target the same pin, and an external event on pin 9 can coincide with a pulse step of the sequencer. Each case is provoked by driving both sources in one cycle, with values chosen so that each possible order leaves a different bit 1 or a different edge interrupt. The test then reads the byte back and checks the interrupt output against the order stated in R12.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

    localparam int OE_BIT  = 2;
    localparam int ST_BIT  = 1;
    localparam int VAL_BIT = 0;

    typedef enum logic [1:0] {
        NMI_IDLE = 2'd0,
        NMI_HIGH = 2'd1,
        NMI_LOW  = 2'd2
    } nmi_state_e;

    typedef struct packed {
        logic [7:0] rdata;
        logic       irq_lvl;
        logic       irq_edge;
        logic       err_oe;
        logic       err_unrt;
    } top_regs_t;

endpackage

// File: rtl/gpio_nmi_seq.sv
module gpio_nmi_seq
    import gpio_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_req,
    output logic step_vld,
    output logic step_val
);

    nmi_state_e st_d, st_q;

    always_comb begin
        st_d = st_q;
        case (st_q)
            NMI_IDLE: if (nmi_req) st_d = NMI_HIGH;
            NMI_HIGH: st_d = NMI_LOW;
            default:  st_d = NMI_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= NMI_IDLE;
        else        st_q <= st_d;
    end

    assign step_vld = (st_q != NMI_IDLE);
    assign step_val = (st_q == NMI_HIGH);

    // R9: the high step is always followed by the low step
    a_r9_high_then_low: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && step_val) |=> (step_vld && !step_val));

    // R9: a request during the low step starts no new sequence
    a_r9_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (step_vld && !step_val) |=> !step_vld);

endmodule

// File: rtl/gpio_pin_cell.sv
module gpio_pin_cell
    import gpio_ctl_pkg::*;
#(
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_hit,
    input  logic [7:0] wdata,
    input  logic       evt_hit,
    input  logic       evt_state,
    input  logic       seq_hit,
    input  logic       seq_state,
    output logic [7:0] byte_q,
    output logic       sig_chg,
    output logic       sig_state
);

    logic [7:0] byte_d;
    logic [7:0] after_wr;
    logic [7:0] after_ev;
    logic       ev_chg;
    logic       seq_chg;

    always_comb begin
        after_wr = byte_q;
        if (wr_hit) begin
            after_wr         = wdata;
            after_wr[ST_BIT] = wdata[OE_BIT] ? wdata[VAL_BIT] : byte_q[ST_BIT];
        end
        after_ev = after_wr;
        ev_chg   = 1'b0;
        if (evt_hit) begin
            after_ev[ST_BIT] = evt_state;
            ev_chg           = (evt_state != after_wr[ST_BIT]);
        end
        byte_d  = after_ev;
        seq_chg = 1'b0;
        if (seq_hit) begin
            byte_d[ST_BIT] = seq_state;
            seq_chg        = (seq_state != after_ev[ST_BIT]);
        end
        sig_chg   = ev_chg || seq_chg;
        sig_state = byte_d[ST_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) byte_q <= RST_VAL;
        else        byte_q <= byte_d;
    end

    // R5: a lone write lands in every field except the state bit
    a_r5_write_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !evt_hit && !seq_hit) |=>
            (byte_q[7:3] == $past(wdata[7:3]) && byte_q[OE_BIT] == $past(wdata[OE_BIT])
             && byte_q[VAL_BIT] == $past(wdata[VAL_BIT])));

    // R6: an event sets the state bit when no sequencer step follows it
    a_r6_event_state: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_hit && !seq_hit) |=> (byte_q[ST_BIT] == $past(evt_state)));

    // R12: the sequencer step is applied last
    a_r12_seq_last: assert property (@(posedge clk) disable iff (!rst_n)
        seq_hit |=> (byte_q[ST_BIT] == $past(seq_state)));

endmodule

// File: rtl/gpio_ctl_regfile.sv
module gpio_ctl_regfile
    import gpio_ctl_pkg::*;
#(
    parameter int NPINS     = 36,
    parameter int LVL_BYTES = 8,
    parameter int AW        = 6,
    parameter int IW        = 6,
    parameter int LVL_PIN   = 1,
    parameter int EDGE_PIN  = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_rd,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    output logic [7:0]    bus_rdata,
    input  logic          pin_evt_valid,
    input  logic [IW-1:0] pin_evt_idx,
    input  logic          pin_evt_state,
    input  logic          nmi_req,
    output logic          irq_level_n_pin,
    output logic          irq_edge_pin,
    output logic          err_in_on_output,
    output logic          err_unrouted
);

    localparam int CTRL_BASE = LVL_BYTES;
    localparam int CTRL_END  = LVL_BYTES + NPINS;

    logic [7:0]       pin_byte [NPINS];
    logic [NPINS-1:0] cell_chg;
    logic [NPINS-1:0] cell_st;
    logic             step_vld;
    logic             step_val;

    gpio_nmi_seq u_nmi (
        .clk      (clk),
        .rst_n    (rst_n),
        .nmi_req  (nmi_req),
        .step_vld (step_vld),
        .step_val (step_val)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        localparam logic [7:0] RV = (g == LVL_PIN) ? 8'h02 : 8'h00;
        gpio_pin_cell #(.RST_VAL(RV)) u_cell (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_hit    (bus_wr && (bus_addr == AW'(CTRL_BASE + g))),
            .wdata     (bus_wdata),
            .evt_hit   (pin_evt_valid && (pin_evt_idx == IW'(g))),
            .evt_state (pin_evt_state),
            .seq_hit   ((g == EDGE_PIN) && step_vld),
            .seq_state (step_val),
            .byte_q    (pin_byte[g]),
            .sig_chg   (cell_chg[g]),
            .sig_state (cell_st[g])
        );
    end

    top_regs_t cur_q, nxt_d;
    logic [7:0] rd_look;
    logic       evt_oe;

    always_comb begin
        rd_look = 8'h00;
        evt_oe  = 1'b0;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr == AW'(CTRL_BASE + i)) rd_look = pin_byte[i];
            if (pin_evt_idx == IW'(i))          evt_oe  = pin_byte[i][OE_BIT];
        end
    end

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.err_oe   = 1'b0;
        nxt_d.err_unrt = 1'b0;
        if (bus_rd) nxt_d.rdata = rd_look;
        if (cell_chg[LVL_PIN])  nxt_d.irq_lvl  = !cell_st[LVL_PIN];
        if (cell_chg[EDGE_PIN]) nxt_d.irq_edge = cell_st[EDGE_PIN];
        if (pin_evt_valid) begin
            nxt_d.err_oe   = evt_oe;
            nxt_d.err_unrt = (pin_evt_idx != IW'(LVL_PIN)) && (pin_evt_idx != IW'(EDGE_PIN));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign bus_rdata        = cur_q.rdata;
    assign irq_level_n_pin  = cur_q.irq_lvl;
    assign irq_edge_pin     = cur_q.irq_edge;
    assign err_in_on_output = cur_q.err_oe;
    assign err_unrouted     = cur_q.err_unrt;

    // R3: level bytes read as zero
    a_r3_level_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (32'(bus_addr) < CTRL_BASE)) |=> (bus_rdata == 8'h00));

    // R4: offsets above the control bytes read as zero
    a_r4_high_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (32'(bus_addr) >= CTRL_END)) |=> (bus_rdata == 8'h00));

    // R2: read data holds without a read strobe
    a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R7: without an event the level interrupt does not move
    a_r7_level_only_on_event: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_evt_valid |=> $stable(irq_level_n_pin));

    // R11: event on an unrouted pin raises the flag
    a_r11_unrouted_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_evt_valid && pin_evt_idx != IW'(LVL_PIN) && pin_evt_idx != IW'(EDGE_PIN))
            |=> err_unrouted);

    // R10, R11: flags are single-cycle pulses tied to events
    a_r10_flags_need_event: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_evt_valid |=> (!err_in_on_output && !err_unrouted));

endmodule

// File: tb/gpio_ctl_regfile_bench.sv
module gpio_ctl_regfile_bench;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [5:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pin_evt_valid = 1'b0;
    logic [5:0] pin_evt_idx = '0;
    logic       pin_evt_state = 1'b0;
    logic       nmi_req = 1'b0;
    logic       irq_level_n_pin, irq_edge_pin, err_in_on_output, err_unrouted;

    int n_vec = 0;
    int n_bad = 0;
    logic [7:0] exp_b [36];

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_ctl_regfile u_gpio_ctl_regfile (
        .clk(clk), .rst_n(rst_n),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_evt_valid(pin_evt_valid), .pin_evt_idx(pin_evt_idx),
        .pin_evt_state(pin_evt_state), .nmi_req(nmi_req),
        .irq_level_n_pin(irq_level_n_pin), .irq_edge_pin(irq_edge_pin),
        .err_in_on_output(err_in_on_output), .err_unrouted(err_unrouted)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        tick();
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic ev(input logic [5:0] i, input logic s);
        pin_evt_valid = 1'b1; pin_evt_idx = i; pin_evt_state = s;
        tick();
        pin_evt_valid = 1'b0;
    endtask

    function automatic logic [7:0] mdl_wr(input logic [7:0] old, input logic [7:0] d);
        logic [7:0] r;
        r = d;
        r[1] = d[2] ? d[0] : old[1];
        return r;
    endfunction

    task automatic verify_all(input string req);
        logic [7:0] d;
        for (int i = 0; i < 36; i++) begin
            rd(6'(8 + i), d);
            chk(req, d, exp_b[i]);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < 36; i++) exp_b[i] = 8'h00;
        exp_b[1] = 8'h02;
        chk("R1 irq_level", {7'd0, irq_level_n_pin}, 8'h00);
        chk("R1 irq_edge", {7'd0, irq_edge_pin}, 8'h00);
        chk("R1 flags", {6'd0, err_in_on_output, err_unrouted}, 8'h00);
        chk("R1 rdata", bus_rdata, 8'h00);
        verify_all("R1 reset bytes");
    endtask

    task automatic t_windows();
        logic [7:0] d;
        wr(6'd3, 8'hFF);
        wr(6'd0, 8'h07);
        rd(6'd3, d); chk("R3 level read", d, 8'h00);
        rd(6'd7, d); chk("R3 level read", d, 8'h00);
        wr(6'd44, 8'hFF);
        wr(6'd63, 8'h05);
        rd(6'd44, d); chk("R4 high read", d, 8'h00);
        rd(6'd50, d); chk("R4 high read", d, 8'h00);
        verify_all("R3 R4 writes ignored");
    endtask

    task automatic t_write();
        logic [7:0] d;
        wr(6'd8 + 6'd4, 8'hA3);  exp_b[4]  = mdl_wr(exp_b[4], 8'hA3);
        rd(6'd12, d); chk("R5 oe=0 keeps bit1", d, 8'hA1);
        wr(6'd12, 8'h05);        exp_b[4]  = mdl_wr(exp_b[4], 8'h05);
        rd(6'd12, d); chk("R5 oe=1 copies bit0", d, 8'h07);
        wr(6'd12, 8'h04);        exp_b[4]  = mdl_wr(exp_b[4], 8'h04);
        rd(6'd12, d); chk("R5 oe=1 copies 0", d, 8'h04);
        wr(6'd43, 8'h5A);        exp_b[35] = mdl_wr(exp_b[35], 8'h5A);
        rd(6'd43, d); chk("R5 last pin", d, 8'h58);
        // R2: rdata holds after a read with no new strobe
        tick(); tick();
        chk("R2 rdata hold", bus_rdata, 8'h58);
    endtask

    task automatic t_event();
        logic [7:0] d;
        ev(6'd3, 1'b1); exp_b[3][1] = 1'b1;
        chk("R11 unrouted flag", {7'd0, err_unrouted}, 8'h01);
        chk("R10 no oe flag", {7'd0, err_in_on_output}, 8'h00);
        tick();
        chk("R11 flag one cycle", {7'd0, err_unrouted}, 8'h00);
        ev(6'd4, 1'b1); exp_b[4][1] = 1'b1;
        chk("R10 oe flag", {7'd0, err_in_on_output}, 8'h01);
        rd(6'd12, d); chk("R10 bit1 still updated", d, 8'h06);
        ev(6'd40, 1'b1);
        chk("R11 out of range flag", {7'd0, err_unrouted}, 8'h01);
        verify_all("R6 event bit1 only");
    endtask

    task automatic t_pin1();
        ev(6'd1, 1'b0); exp_b[1][1] = 1'b0;
        chk("R7 assert on low", {7'd0, irq_level_n_pin}, 8'h01);
        chk("R11 pin1 no flag", {7'd0, err_unrouted}, 8'h00);
        ev(6'd1, 1'b0);
        chk("R7 no change keeps", {7'd0, irq_level_n_pin}, 8'h01);
        wr(6'd9, 8'h05); exp_b[1] = mdl_wr(exp_b[1], 8'h05);
        tick();
        chk("R7 write does not move irq", {7'd0, irq_level_n_pin}, 8'h01);
        ev(6'd1, 1'b1);
        chk("R7 unchanged byte keeps irq", {7'd0, irq_level_n_pin}, 8'h01);
        chk("R10 pin1 output flag", {7'd0, err_in_on_output}, 8'h01);
        ev(6'd1, 1'b0); exp_b[1][1] = 1'b0;
        ev(6'd1, 1'b1); exp_b[1][1] = 1'b1;
        chk("R7 deassert on high", {7'd0, irq_level_n_pin}, 8'h00);
        verify_all("R7 bytes");
    endtask

    task automatic t_pin9();
        ev(6'd9, 1'b1); exp_b[9][1] = 1'b1;
        chk("R8 rise", {7'd0, irq_edge_pin}, 8'h01);
        ev(6'd9, 1'b1);
        chk("R8 repeat keeps", {7'd0, irq_edge_pin}, 8'h01);
        ev(6'd9, 1'b0); exp_b[9][1] = 1'b0;
        chk("R8 fall", {7'd0, irq_edge_pin}, 8'h00);
    endtask

    task automatic t_nmi();
        logic [7:0] d;
        nmi_req = 1'b1;
        tick();
        chk("R9 not yet", {7'd0, irq_edge_pin}, 8'h00);
        tick();
        chk("R9 pulse high", {7'd0, irq_edge_pin}, 8'h01);
        tick();
        chk("R9 pulse low", {7'd0, irq_edge_pin}, 8'h00);
        nmi_req = 1'b0;
        tick();
        chk("R9 held request ignored", {7'd0, irq_edge_pin}, 8'h00);
        tick();
        chk("R9 held request ignored", {7'd0, irq_edge_pin}, 8'h00);
        rd(6'd17, d); chk("R9 pin9 ends low", d, exp_b[9]);
    endtask

    task automatic t_collide();
        logic [7:0] d;
        bus_wr = 1'b1; bus_addr = 6'd14; bus_wdata = 8'h07;
        pin_evt_valid = 1'b1; pin_evt_idx = 6'd6; pin_evt_state = 1'b0;
        tick();
        bus_wr = 1'b0; pin_evt_valid = 1'b0;
        exp_b[6] = 8'h05;
        chk("R12 write then event flag", {6'd0, err_in_on_output, err_unrouted}, 8'h01);
        rd(6'd14, d); chk("R12 event wins over write", d, 8'h05);
        ev(6'd9, 1'b1); exp_b[9][1] = 1'b1;
        nmi_req = 1'b1;
        tick();
        nmi_req = 1'b0;
        ev(6'd9, 1'b0);
        chk("R12 sequencer wins over event", {7'd0, irq_edge_pin}, 8'h01);
        tick();
        chk("R12 pulse ends", {7'd0, irq_edge_pin}, 8'h00);
        exp_b[9][1] = 1'b0;
        verify_all("R12 bytes");
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        tick();
        t_reset();
        t_windows();
        t_write();
        t_event();
        t_pin1();
        t_pin9();
        t_nmi();
        t_collide();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule